// File: doc/BRIEF.md
# Chip-Select External Bus Controller

This block sits between an on-chip host and four external memory regions: a boot ROM, a flash device, a static RAM and an expansion window. The host issues single 32-bit reads and writes. The two top address bits pick one of four chip selects. The controller then asserts that chip select together with a read or a write strobe. It holds each bus beat for a programmed number of cycles and returns a one-cycle ready pulse with the assembled read data.

Each region has an 8-bit control word. The word gives the beat length, a synchronous-mode flag, a write permission and the bus width of the device. A narrow device is served by splitting one host access into several beats. The control words sit behind a lock. Out of reset the lock is closed. Only a write of the key 0xA05F to the lock offset opens it, and a write of any other value to that offset closes it again.

The access sequencer has four states: IDLE, ACCESS, DONE and REJECT.
- IDLE goes to ACCESS when a request arrives.
- IDLE goes to REJECT when the request is a write to a region whose write permission is clear.
- ACCESS stays in ACCESS until the last cycle of the last beat, then goes to DONE.
- DONE and REJECT each last one cycle and return to IDLE.

Top module: `xbus_csel_ctrl`

## Requirements
- R1: After reset the lock is closed (reading offset 0x20 returns 1 in bit 0), every control word reads 0xF0, no chip select or strobe is active and ready is low.
- R2: While the lock is closed, a write to any control word leaves its value unchanged.
- R3: Writing 0xA05F to offset 0x20 opens the lock (bit 0 reads 0). Writing any other value there closes it (bit 0 reads 1).
- R4: The control words of chip selects 0, 1, 2 and 3 sit at offsets 0x00, 0x04, 0x08 and 0x0C. Each reads back in bits 7:0 with zeros above. The layout is bits 7:4 wait field, bit 3 mode, bit 2 write permission and bits 1:0 width. Unmapped offsets read 0.
- R5: Request address bits 27:26 select the chip select. While an access runs, exactly that one chip-select bit is high and it does not change. It is low otherwise.
- R6: Every beat lasts n+2 cycles for a wait field n from 0 to 13, and 16 cycles for fields 14 and 15.
- R7: Width code 00 gives four 1-byte beats, 01 gives two 2-byte beats, and 10 or 11 give one 4-byte beat. During beat k, the memory address is the request address plus k times the beat size in bytes. The memory write data is the host write data shifted right by 8 times k times the beat size.
- R8: A read returns its data with a single-cycle ready in the cycle after the last beat. The lanes of beat k are placed little-endian at byte position k times the beat size.
- R9: A write to a region whose write permission is 0 gives ready and the error flag one cycle after it is accepted. No chip select and no write strobe are raised.
- R10: The mode bit of the active region appears on mem_sync during the access. It is 0 when no access runs and has no effect on timing.
- R11: The read strobe is high only during read accesses and the write strobe only during write accesses. The two are never high together, and both are low outside an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration access enable |
| cfg_we | input | 1 | Configuration write when high |
| cfg_addr | input | 6 | Configuration byte offset |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data, combinational on cfg_addr |
| req_valid | input | 1 | Host request, sampled while idle |
| req_write | input | 1 | Host request is a write |
| req_addr | input | 28 | Host byte address; bits 27:26 pick the region |
| req_wdata | input | 32 | Host write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Completion was a blocked write |
| req_rdata | output | 32 | Assembled read data, valid with req_ready |
| mem_cs | output | 4 | One-hot chip selects |
| mem_oe | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_sync | output | 1 | Mode bit of the active region |
| mem_addr | output | 28 | Beat address |
| mem_wdata | output | 32 | Beat write data in the low lanes |
| mem_din | input | 32 | Device read data in the low lanes |

## Verification
A wrong beat or wait counter shows up at once as a beat address that advances one cycle early or late, and as a ready pulse that moves. This is caught on the very cycle it departs from the expected trace. A corrupted lane offset or width decode survives the whole access and appears only as wrong bytes in the read data, or as a wrong shifted write word, one beat in. A broken lock or decode does not disturb the bus at all until a later access runs with the wrong timing. For that reason, every control word is also read back directly after each lock change.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_DONE,
        ST_REJECT
    } bus_state_e;

    // Control word of one region; field positions are software visible.
    typedef struct packed {
        logic [3:0] wait_f;
        logic       sync;
        logic       wr_en;
        logic [1:0] width;
    } region_cfg_t;

    localparam logic [7:0]  REGION_CFG_RST = 8'hF0;
    localparam logic [15:0] UNLOCK_KEY     = 16'hA05F;

    // Beat length in cycles: field + 2, saturating at 16.
    function automatic logic [4:0] wait_len(input logic [3:0] f);
        if (f >= 4'd14) return 5'd16;
        return {1'b0, f} + 5'd2;
    endfunction

    // log2 of the beat size in bytes.
    function automatic logic [1:0] width_log2(input logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
    import xbus_pkg::*;
#(
    parameter int              NUM_CS   = 4,
    parameter int              CFG_AW   = 6,
    parameter int              CFG_DW   = 16,
    parameter logic [CFG_AW-1:0] LOCK_OFS = 6'h20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_en,
    input  logic                       cfg_we,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [CFG_DW-1:0]          cfg_wdata,
    output logic [CFG_DW-1:0]          cfg_rdata,
    output region_cfg_t [NUM_CS-1:0]   region_cfg
);

    logic locked_q;
    logic wr_hit;

    assign wr_hit = cfg_en && cfg_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            locked_q <= 1'b1;
        else if (wr_hit && cfg_addr == LOCK_OFS)
            locked_q <= (cfg_wdata != UNLOCK_KEY);
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        localparam logic [CFG_AW-1:0] OFS = CFG_AW'(g * 4);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                region_cfg[g] <= region_cfg_t'(REGION_CFG_RST);
            else if (wr_hit && !locked_q && cfg_addr == OFS)
                region_cfg[g] <= region_cfg_t'(cfg_wdata[7:0]);
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == LOCK_OFS)
            cfg_rdata = {{(CFG_DW-1){1'b0}}, locked_q};
        for (int i = 0; i < NUM_CS; i++) begin
            if (cfg_addr == CFG_AW'(i * 4))
                cfg_rdata = {{(CFG_DW-8){1'b0}}, region_cfg[i]};
        end
    end

endmodule

// File: rtl/xbus_access_fsm.sv
module xbus_access_fsm
    import xbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  region_cfg_t [NUM_CS-1:0]  region_cfg,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      req_ready,
    output logic                      req_err,
    output logic [DATA_W-1:0]         req_rdata,
    output logic [NUM_CS-1:0]         mem_cs,
    output logic                      mem_oe,
    output logic                      mem_we,
    output logic                      mem_sync,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_din
);

    localparam int SEL_W     = $clog2(NUM_CS);
    localparam int NUM_BYTES = DATA_W / 8;
    localparam int LANE_W    = $clog2(NUM_BYTES);

    bus_state_e          state_q, state_d;
    region_cfg_t         cfg_q, cfg_in;
    logic [SEL_W-1:0]    sel_q, sel_in;
    logic                write_q;
    logic [ADDR_W-1:0]   base_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q, rd_merge;
    logic [4:0]          cnt_q;
    logic [LANE_W-1:0]   beat_q, lane_ofs, last_beat, lane_idx;
    logic [1:0]          lg;
    logic                beat_end, last_end;

    assign sel_in    = req_addr[ADDR_W-1 -: SEL_W];
    assign cfg_in    = region_cfg[sel_in];
    assign lg        = width_log2(cfg_q.width);
    assign lane_ofs  = LANE_W'(beat_q << lg);
    assign last_beat = LANE_W'((NUM_BYTES >> lg) - 1);
    assign beat_end  = (cnt_q == wait_len(cfg_q.wait_f) - 5'd1);
    assign last_end  = beat_end && (beat_q == last_beat);

    assign mem_addr  = base_q + ADDR_W'(lane_ofs);
    assign mem_wdata = wdata_q >> {lane_ofs, 3'b000};
    assign req_rdata = rdata_q;

    // Place the device lanes of the current beat into the result word.
    always_comb begin
        rd_merge = rdata_q;
        lane_idx = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            lane_idx = lane_ofs + LANE_W'(i);
            if (i < (1 << lg))
                rd_merge[8*lane_idx +: 8] = mem_din[8*i +: 8];
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        req_err   = 1'b0;
        mem_cs    = '0;
        mem_oe    = 1'b0;
        mem_we    = 1'b0;
        mem_sync  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid)
                    state_d = (req_write && !cfg_in.wr_en) ? ST_REJECT : ST_ACCESS;
            end
            ST_ACCESS: begin
                mem_cs   = NUM_CS'(1) << sel_q;
                mem_oe   = !write_q;
                mem_we   = write_q;
                mem_sync = cfg_q.sync;
                if (last_end) state_d = ST_DONE;
            end
            ST_DONE: begin
                req_ready = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_REJECT: begin
                req_ready = 1'b1;
                req_err   = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture, beat and wait counters, read assembly.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= region_cfg_t'(REGION_CFG_RST);
            sel_q   <= '0;
            write_q <= 1'b0;
            base_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            cnt_q   <= '0;
            beat_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            cfg_q   <= cfg_in;
            sel_q   <= sel_in;
            write_q <= req_write;
            base_q  <= req_addr;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            cnt_q   <= '0;
            beat_q  <= '0;
        end else if (state_q == ST_ACCESS) begin
            if (beat_end) begin
                cnt_q  <= '0;
                beat_q <= beat_q + LANE_W'(1);
                if (!write_q) rdata_q <= rd_merge;
            end else begin
                cnt_q <= cnt_q + 5'd1;
            end
        end
    end

endmodule

// File: rtl/xbus_csel_ctrl.sv
module xbus_csel_ctrl
    import xbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32,
    parameter int CFG_AW = 6,
    parameter int CFG_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              req_err,
    output logic [DATA_W-1:0] req_rdata,
    output logic [NUM_CS-1:0] mem_cs,
    output logic              mem_oe,
    output logic              mem_we,
    output logic              mem_sync,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_din
);

    region_cfg_t [NUM_CS-1:0] region_cfg;

    xbus_cfg_regs #(
        .NUM_CS (NUM_CS),
        .CFG_AW (CFG_AW),
        .CFG_DW (CFG_DW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .region_cfg (region_cfg)
    );

    xbus_access_fsm #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .region_cfg (region_cfg),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .req_err    (req_err),
        .req_rdata  (req_rdata),
        .mem_cs     (mem_cs),
        .mem_oe     (mem_oe),
        .mem_we     (mem_we),
        .mem_sync   (mem_sync),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_din    (mem_din)
    );

endmodule

// File: rtl/xbus_checks.sv
module xbus_checks #(
    parameter int NUM_CS = 4,
    parameter int CFG_AW = 6,
    parameter int CFG_DW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_en,
    input logic                  cfg_we,
    input logic [CFG_AW-1:0]     cfg_addr,
    input logic [CFG_DW-1:0]     cfg_wdata,
    input logic [CFG_DW-1:0]     cfg_rdata,
    input logic [8*NUM_CS-1:0]   cfg_flat,
    input logic [NUM_CS-1:0]     mem_cs,
    input logic                  mem_oe,
    input logic                  mem_we,
    input logic                  mem_sync,
    input logic                  req_ready,
    input logic                  req_err
);

    localparam logic [CFG_AW-1:0] LOCK_OFS = CFG_AW'(32);
    localparam logic [CFG_DW-1:0] KEY      = CFG_DW'(16'hA05F);

    // Lock state tracked from the configuration port alone.
    logic shadow_locked;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shadow_locked <= 1'b1;
        else if (cfg_en && cfg_we && cfg_addr == LOCK_OFS)
            shadow_locked <= (cfg_wdata != KEY);
    end

    assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));

    assert_cs_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs != '0) |=> (mem_cs == '0 || $stable(mem_cs)));

    assert_wait_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs != '0) |=> (mem_cs != '0));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs != '0) |-> (mem_oe ^ mem_we));

    assert_strobe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs == '0) |-> (!mem_oe && !mem_we));

    assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && mem_cs == '0 && !mem_we));

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_sync_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs == '0) |-> !mem_sync);

    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_we && shadow_locked && cfg_addr != LOCK_OFS) |=> $stable(cfg_flat));

    assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_we && cfg_addr == LOCK_OFS && cfg_wdata != KEY)
        |=> (cfg_addr != LOCK_OFS || cfg_rdata[0]));

endmodule

bind xbus_csel_ctrl xbus_checks #(
    .NUM_CS (NUM_CS),
    .CFG_AW (CFG_AW),
    .CFG_DW (CFG_DW)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_flat  (region_cfg),
    .mem_cs    (mem_cs),
    .mem_oe    (mem_oe),
    .mem_we    (mem_we),
    .mem_sync  (mem_sync),
    .req_ready (req_ready),
    .req_err   (req_err)
);

// File: tb/sim_xbus_csel_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_csel_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, req_err;
    logic [31:0] req_rdata;
    logic [3:0]  mem_cs;
    logic        mem_oe, mem_we, mem_sync;
    logic [27:0] mem_addr;
    logic [31:0] mem_wdata, mem_din;

    int n_checks = 0;
    int n_errors = 0;
    bit timeout  = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input logic [27:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign mem_din = {pat(mem_addr + 28'd3), pat(mem_addr + 28'd2),
                      pat(mem_addr + 28'd1), pat(mem_addr)};

    xbus_csel_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_err(req_err),
        .req_rdata(req_rdata), .mem_cs(mem_cs), .mem_oe(mem_oe),
        .mem_we(mem_we), .mem_sync(mem_sync), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_din(mem_din)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          mph;            // 0 idle, 1 busy, 2 done, 3 rejected
    int          mt, mw, mbytes, mtotal, mr;
    logic [7:0]  mreg [4];
    logic [7:0]  mcfg;
    logic [27:0] mbase;
    logic [31:0] mwd;
    bit          mwrite, mlocked;

    function automatic logic [15:0] exp_rd(input logic [5:0] a);
        if (a == 6'h20) return {15'b0, mlocked};
        if (a[1:0] == 2'b00 && a < 6'h10) return {8'h00, mreg[a >> 2]};
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; mlocked = 1'b1;
            for (int i = 0; i < 4; i++) mreg[i] = 8'hF0;
        end else begin
            case (mph)
                0: if (req_valid) begin
                    mr = int'(req_addr[27:26]);
                    mcfg = mreg[mr];
                    mwrite = req_write; mbase = req_addr; mwd = req_wdata;
                    if (mwrite && !mcfg[2]) mph = 3;
                    else begin
                        mph = 1; mt = 0;
                        mw = (int'(mcfg[7:4]) + 2 > 16) ? 16 : int'(mcfg[7:4]) + 2;
                        mbytes = (mcfg[1:0] == 2'b00) ? 1 : (mcfg[1:0] == 2'b01) ? 2 : 4;
                        mtotal = mw * (4 / mbytes);
                    end
                end
                1: begin mt++; if (mt == mtotal) mph = 2; end
                default: mph = 0;
            endcase
            if (cfg_en && cfg_we) begin
                if (cfg_addr == 6'h20) mlocked = (cfg_wdata != 16'hA05F);
                else if (!mlocked && cfg_addr[1:0] == 2'b00 && cfg_addr < 6'h10)
                    mreg[cfg_addr >> 2] = cfg_wdata[7:0];
            end
        end
        #1;
        compare_cycle();
    end

    task automatic compare_cycle();
        logic [3:0]  e_cs;
        logic [31:0] e_rd;
        int beat;
        e_cs = (mph == 1) ? (4'b0001 << mr) : 4'b0000;
        check(mem_cs === e_cs, "R5 chip select", 32'(mem_cs), 32'(e_cs));
        check(mem_oe === (mph == 1 && !mwrite), "R11 read strobe", 32'(mem_oe), 32'(mph == 1 && !mwrite));
        check(mem_we === (mph == 1 && mwrite), "R11 write strobe", 32'(mem_we), 32'(mph == 1 && mwrite));
        check(mem_sync === (mph == 1 && mcfg[3]), "R10 sync output", 32'(mem_sync), 32'(mph == 1 && mcfg[3]));
        check(req_ready === (mph >= 2), "R8 ready timing", 32'(req_ready), 32'(mph >= 2));
        check(req_err === (mph == 3), "R9 error flag", 32'(req_err), 32'(mph == 3));
        check(cfg_rdata === exp_rd(cfg_addr), "R4 config readback", 32'(cfg_rdata), 32'(exp_rd(cfg_addr)));
        if (mph == 1) begin
            beat = mt / mw;
            check(mem_addr === mbase + 28'(beat * mbytes), "R7 beat address",
                  32'(mem_addr), 32'(mbase + 28'(beat * mbytes)));
            if (mwrite)
                check(mem_wdata === (mwd >> (8 * mbytes * beat)), "R7 beat write data",
                      mem_wdata, mwd >> (8 * mbytes * beat));
        end
        if (mph == 2 && !mwrite) begin
            e_rd = {pat(mbase + 28'd3), pat(mbase + 28'd2), pat(mbase + 28'd1), pat(mbase)};
            check(req_rdata === e_rd, "R8 read data", req_rdata, e_rd);
        end
    endtask

    // ---------------- stimulus ----------------
    task automatic cfg_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] a, input logic [15:0] e, input string tag);
        @(negedge clk); cfg_addr = a;
        #1 check(cfg_rdata === e, tag, 32'(cfg_rdata), 32'(e));
    endtask

    task automatic do_access(input bit wr, input logic [27:0] a, input logic [31:0] d,
                             input int exp_lat, input string tag);
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk);
            if (n == 0) req_valid = 1'b0;
            n++;
        end while (!req_ready && n < 300);
        check(n == exp_lat, tag, 32'(n), 32'(exp_lat));
        @(negedge clk);
    endtask

    task automatic run_all();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cfg_read(6'h20, 16'h0001, "R1 locked after reset");
        cfg_read(6'h08, 16'h00F0, "R1 control word reset value");
        check(mem_cs === 4'b0 && !req_ready, "R1 bus idle after reset", 32'(mem_cs), 32'h0);
        // R2 locked writes dropped
        cfg_write(6'h04, 16'h003D);
        cfg_read(6'h04, 16'h00F0, "R2 write ignored while locked");
        // R3 lock behaviour
        cfg_write(6'h20, 16'h1234);
        cfg_read(6'h20, 16'h0001, "R3 wrong key keeps lock");
        cfg_write(6'h20, 16'hA05F);
        cfg_read(6'h20, 16'h0000, "R3 key opens lock");
        // R4 programming and readback
        cfg_write(6'h00, 16'h0000);
        cfg_write(6'h04, 16'h003D);
        cfg_write(6'h08, 16'h00E6);
        cfg_write(6'h0C, 16'h0057);
        cfg_read(6'h00, 16'h0000, "R4 cs0 word");
        cfg_read(6'h04, 16'h003D, "R4 cs1 word");
        cfg_read(6'h08, 16'h00E6, "R4 cs2 word");
        cfg_read(6'h0C, 16'h0057, "R4 cs3 word");
        cfg_read(6'h10, 16'h0000, "R4 unmapped offset");
        // Reads: R6 timing, R7 beats, R8 assembly
        do_access(1'b0, 28'h0000101, 32'h0, 9,  "R7 8-bit read four beats of 2");
        do_access(1'b0, 28'h4000206, 32'h0, 11, "R7 16-bit read two beats of 5");
        do_access(1'b0, 28'h8000010, 32'h0, 17, "R6 field 14 gives 16 cycles");
        do_access(1'b0, 28'hC0000F8, 32'h0, 8,  "R7 width code 11 as 32-bit");
        // R9 blocked write
        do_access(1'b1, 28'h0000040, 32'hDEADBEEF, 1, "R9 blocked write latency");
        // Writes
        do_access(1'b1, 28'h4000300, 32'hA1B2C3D4, 11, "R7 16-bit write");
        do_access(1'b1, 28'h8000020, 32'h01234567, 17, "R7 32-bit write");
        do_access(1'b1, 28'hC000004, 32'h89ABCDEF, 8,  "R10 async write timing");
        cfg_write(6'h0C, 16'h00DF);
        do_access(1'b0, 28'hC000030, 32'h0, 16, "R6 field 13 gives 15 cycles");
        // Relock, then refused update
        cfg_write(6'h20, 16'h0000);
        cfg_read(6'h20, 16'h0001, "R3 other value relocks");
        cfg_write(6'h00, 16'h00FF);
        cfg_read(6'h00, 16'h0000, "R2 relocked write ignored");
        cfg_write(6'h20, 16'hA05F);
        cfg_write(6'h00, 16'h00F4);
        cfg_read(6'h00, 16'h00F4, "R4 cs0 reprogrammed");
        do_access(1'b1, 28'h00000FE, 32'h55AA33CC, 65, "R6 field 15 8-bit write");
        do_access(1'b0, 28'h00000FC, 32'h0, 65, "R8 8-bit read field 15");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1;
            end
        join_any
        if (timeout) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule